// File: doc/BRIEF.md
# Condition Field Predicate Reducer

This unit picks one 4-bit field out of a 32-bit condition register and compares each bit with a programmable expected value, under an enable mask. It then turns the comparison into a 64-bit integer result. In single-bit mode the result is one predicate bit. With the mode bit set, that bit is true when any enabled bit matches. With the mode bit clear, it is true only when every enabled bit matches. In vector mode the result holds the four per-bit match flags instead. It is meant for building integer predicate masks from comparison outcomes.

When the summary enable is set, the unit also produces a 4-bit summary of the integer result, together with a write strobe. Operands are captured on an input strobe. The result, the summary and the output strobe appear one clock later and hold until the next operation.

Top module: `crpred_unit`

## Requirements
- R1: `fld_sel` = k selects condition register bits [31-4k : 28-4k], so k = 0 is the top nibble. Within the selected field, bit 3 is the field's most significant (first) bit.
- R2: The match vector is n[i] = `fld_mask[i]` & (`fld_map[i]` == field[i]) for i = 0..3, where bit 3 of mask and map pairs with the field's first bit.
- R3: In single-bit mode with `any_mode` = 1, the predicate is 1 exactly when some bit of n is 1.
- R4: In single-bit mode with `any_mode` = 0, the predicate is 1 exactly when n equals `fld_mask`.
- R5: With `fld_mask` = 0 in single-bit mode, the predicate is 1 when `any_mode` = 0 and 0 when `any_mode` = 1.
- R6: In single-bit mode (`vec_mode` = 0), `result[0]` is the predicate and `result[63:1]` is zero.
- R7: In vector mode (`vec_mode` = 1), `result[3:0]` is n, so the field's first bit lands in bit 3, and `result[63:4]` is zero.
- R8: The summary is {negative, positive-nonzero, zero, `ovf_in`} of the result read as a signed value, with bit 3 the negative flag and bit 0 the copied overflow input. `summ_we` is 1 exactly when the output strobe is 1 and the captured `summ_en` was 1.
- R9: `out_valid` is 1 exactly one cycle after a cycle with `in_valid` = 1. `result` and `summary` change only in the cycle after an `in_valid` and otherwise hold their values.
- R10: During reset and after it, until the first operation, `out_valid`, `summ_we`, `result` and `summary` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand capture strobe |
| cr_value | input | 32 | Condition register contents |
| fld_sel | input | 3 | Field index |
| fld_mask | input | 4 | Per-bit enable mask |
| fld_map | input | 4 | Per-bit expected values |
| any_mode | input | 1 | 1: any-match reduction, 0: all-match reduction |
| vec_mode | input | 1 | 1: emit match vector, 0: emit single predicate |
| summ_en | input | 1 | Request summary field |
| ovf_in | input | 1 | Summary-overflow value copied into the summary |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Integer result |
| summary | output | 4 | Summary flags of the result |
| summ_we | output | 1 | Summary write enable |

## Verification
The assertions expect the inputs to carry meaningful values only in cycles where `in_valid` is high. Outside those cycles they expect nothing beyond reset being applied synchronously. The stimulus keeps this by driving every operand at the falling edge, together with its strobe. It then leaves idle gaps with random operand noise and `in_valid` low, so that the hold property is exercised against changing inputs. Random operations cover every field index and every mode combination. Directed cases cover a zero mask, a full mask and field selections at both ends of the register.

// File: rtl/crpred_pkg.sv
package crpred_pkg;
    localparam int CR_W  = 32;
    localparam int FLD_W = 4;
    localparam int RES_W = 64;
    localparam int SUM_W = 4;

    typedef struct packed {
        logic             out_valid;
        logic [RES_W-1:0] result;
        logic [SUM_W-1:0] summary;
        logic             summ_we;
    } out_state_t;
endpackage

// File: rtl/crpred_field_sel.sv
module crpred_field_sel #(
    parameter int CR_W  = 32,
    parameter int FLD_W = 4,
    localparam int NFLD  = CR_W / FLD_W,
    localparam int SEL_W = $clog2(NFLD)
) (
    input  logic [CR_W-1:0]  cr_value,
    input  logic [SEL_W-1:0] fld_sel,
    output logic [FLD_W-1:0] field
);
    always_comb begin
        field = '0;
        for (int k = 0; k < NFLD; k++) begin
            if (fld_sel == SEL_W'(k))
                field = cr_value[CR_W-1-FLD_W*k -: FLD_W];
        end
    end
endmodule

// File: rtl/crpred_reduce.sv
module crpred_reduce #(
    parameter int FLD_W = 4,
    parameter int RES_W = 64
) (
    input  logic [FLD_W-1:0] field,
    input  logic [FLD_W-1:0] fld_mask,
    input  logic [FLD_W-1:0] fld_map,
    input  logic             any_mode,
    input  logic             vec_mode,
    output logic [RES_W-1:0] result
);
    logic [FLD_W-1:0] hit;
    logic             pred;

    for (genvar i = 0; i < FLD_W; i++) begin : g_bit
        assign hit[i] = fld_mask[i] & ~(fld_map[i] ^ field[i]);
    end

    always_comb begin
        pred = any_mode ? (|hit) : (hit == fld_mask);
        if (vec_mode)
            result = RES_W'(hit);
        else
            result = RES_W'(pred);
    end
endmodule

// File: rtl/crpred_summary.sv
module crpred_summary #(
    parameter int RES_W = 64
) (
    input  logic [RES_W-1:0] result,
    input  logic             ovf_in,
    output logic [3:0]       summary
);
    logic is_neg, is_zero, is_pos;

    always_comb begin
        is_neg  = result[RES_W-1];
        is_zero = (result == '0);
        is_pos  = ~is_neg & ~is_zero;
        summary = {is_neg, is_pos, is_zero, ovf_in};
    end
endmodule

// File: rtl/crpred_unit.sv
module crpred_unit
    import crpred_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      cr_value,
    input  logic [2:0]       fld_sel,
    input  logic [3:0]       fld_mask,
    input  logic [3:0]       fld_map,
    input  logic             any_mode,
    input  logic             vec_mode,
    input  logic             summ_en,
    input  logic             ovf_in,
    output logic             out_valid,
    output logic [63:0]      result,
    output logic [3:0]       summary,
    output logic             summ_we
);
    logic [FLD_W-1:0] field_w;
    logic [RES_W-1:0] res_w;
    logic [SUM_W-1:0] sum_w;
    out_state_t       st_d, st_q;

    crpred_field_sel #(.CR_W(CR_W), .FLD_W(FLD_W)) u_sel (
        .cr_value (cr_value),
        .fld_sel  (fld_sel),
        .field    (field_w)
    );

    crpred_reduce #(.FLD_W(FLD_W), .RES_W(RES_W)) u_red (
        .field    (field_w),
        .fld_mask (fld_mask),
        .fld_map  (fld_map),
        .any_mode (any_mode),
        .vec_mode (vec_mode),
        .result   (res_w)
    );

    crpred_summary #(.RES_W(RES_W)) u_sum (
        .result  (res_w),
        .ovf_in  (ovf_in),
        .summary (sum_w)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = in_valid;
        st_d.summ_we   = in_valid & summ_en;
        if (in_valid) begin
            st_d.result  = res_w;
            st_d.summary = sum_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_valid;
    assign result    = st_q.result;
    assign summary   = st_q.summary;
    assign summ_we   = st_q.summ_we;
endmodule

// File: rtl/crpred_chk.sv
module crpred_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        vec_mode,
    input logic        ovf_in,
    input logic        out_valid,
    input logic [63:0] result,
    input logic [3:0]  summary,
    input logic        summ_we
);
    // R9
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(result) && $stable(summary));

    // R8
    we_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        summ_we |-> out_valid);

    // R8
    flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        summ_we |-> $countones(summary[3:1]) == 1 && summary[1] == (result == 64'd0));

    // R8
    ovf_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> summary[0] == $past(ovf_in));

    // R6
    single_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !vec_mode) |=> result[63:1] == 63'd0);

    // R7
    vector_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vec_mode) |=> result[63:4] == 60'd0);
endmodule

bind crpred_unit crpred_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .vec_mode  (vec_mode),
    .ovf_in    (ovf_in),
    .out_valid (out_valid),
    .result    (result),
    .summary   (summary),
    .summ_we   (summ_we)
);

// File: tb/crpred_unit_tb.sv
module crpred_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] cr_value;
    logic [2:0]  fld_sel;
    logic [3:0]  fld_mask, fld_map;
    logic        any_mode, vec_mode, summ_en, ovf_in;
    logic        out_valid, summ_we;
    logic [63:0] result;
    logic [3:0]  summary;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crpred_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cr_value(cr_value),
        .fld_sel(fld_sel), .fld_mask(fld_mask), .fld_map(fld_map),
        .any_mode(any_mode), .vec_mode(vec_mode), .summ_en(summ_en),
        .ovf_in(ovf_in), .out_valid(out_valid), .result(result),
        .summary(summary), .summ_we(summ_we)
    );

    function automatic logic [63:0] exp_result(logic [31:0] cr, logic [2:0] sel,
            logic [3:0] m, logic [3:0] p, logic anym, logic vec);
        logic [3:0] fld, n;
        logic pr;
        for (int b = 0; b < 4; b++)
            fld[3-b] = cr[31 - 4*int'(sel) - b];
        for (int i = 0; i < 4; i++)
            n[i] = m[i] && (p[i] == fld[i]);
        if (anym) pr = (n != 4'd0);
        else      pr = (n == m);
        return vec ? {60'd0, n} : {63'd0, pr};
    endfunction

    function automatic logic [3:0] exp_summary(logic [63:0] r, logic ov);
        logic neg, zer;
        neg = r[63];
        zer = (r == 64'd0);
        return {neg, !neg && !zer, zer, ov};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(logic [31:0] cr, logic [2:0] sel, logic [3:0] m,
            logic [3:0] p, logic anym, logic vec, logic rc, logic ov, string req);
        logic [63:0] er;
        @(negedge clk);
        in_valid = 1'b1; cr_value = cr; fld_sel = sel; fld_mask = m; fld_map = p;
        any_mode = anym; vec_mode = vec; summ_en = rc; ovf_in = ov;
        er = exp_result(cr, sel, m, p, anym, vec);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R9 valid"}, 64'(out_valid), 64'd1);
        check({req, " result"}, result, er);
        check("R8 we", 64'(summ_we), 64'(rc));
        if (rc) check("R8 summary", 64'(summary), 64'(exp_summary(er, ov)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'd1234));
        rst_n = 1'b0; in_valid = 1'b0; cr_value = '0; fld_sel = '0;
        fld_mask = '0; fld_map = '0; any_mode = 1'b0; vec_mode = 1'b0;
        summ_en = 1'b0; ovf_in = 1'b0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 valid", 64'(out_valid), 64'd0);
        check("R10 we", 64'(summ_we), 64'd0);
        check("R10 result", result, 64'd0);
        check("R10 summary", 64'(summary), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle", result, 64'd0);

        // R1 field ends: top and bottom nibbles, vector mode, full mask, map all ones
        run_op(32'hA000_0005, 3'd0, 4'hF, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0, "R1 top");
        check("R1 R7 top nibble", result, 64'h0000_0000_0000_000A);
        run_op(32'hA000_0005, 3'd7, 4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0, "R1 bottom");
        check("R1 R7 bottom nibble", result, 64'h0000_0000_0000_0005);
        // R2 map zero picks the clear bits, masked
        run_op(32'h0C00_0000, 3'd1, 4'b0111, 4'h0, 1'b1, 1'b1, 1'b1, 1'b1, "R2");
        check("R2 masked match", result, 64'h3);
        // R5 empty mask
        run_op(32'hFFFF_FFFF, 3'd3, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, "R5 all");
        check("R5 all-match empty", result, 64'd1);
        run_op(32'hFFFF_FFFF, 3'd3, 4'h0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b1, "R5 any");
        check("R5 any-match empty", result, 64'd0);
        // R3 / R4 partial match: field 0x9, mask 0xF, map 0x8 -> n = 1110
        run_op(32'h0090_0000, 3'd2, 4'hF, 4'h8, 1'b1, 1'b0, 1'b1, 1'b0, "R3");
        check("R3 any partial", result, 64'd1);
        run_op(32'h0090_0000, 3'd2, 4'hF, 4'h8, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
        check("R4 all partial", result, 64'd0);
        run_op(32'h0090_0000, 3'd2, 4'hE, 4'h8, 1'b0, 1'b0, 1'b0, 1'b0, "R4 R6");
        check("R4 R6 all masked", result, 64'd1);

        // R9 hold across idle cycles with noisy inputs
        held = result;
        for (int k = 0; k < 3; k++) begin
            cr_value = $urandom; fld_mask = 4'($urandom); vec_mode = 1'($urandom);
            @(negedge clk);
            check("R9 idle valid", 64'(out_valid), 64'd0);
            check("R9 hold result", result, held);
            check("R8 idle we", 64'(summ_we), 64'd0);
        end

        // random operations (R1 R2 R3 R4 R6 R7 R8)
        for (int k = 0; k < 400; k++) begin
            run_op($urandom, 3'($urandom), 4'($urandom), 4'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R2 rand");
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule